// File: doc/BRIEF.md
# Scanline Timing and Scroll-Address Sequencer

This block is the timing backbone of a tile-based video generator. A cycle counter walks each scanline and a line counter walks each frame. Together they mark which cycles carry a visible pixel. On visible lines the block also advances a packed video-memory scroll address, so that the fetch logic downstream always sees the tile position it needs.

The scroll address packs four fields: a 5-bit coarse column, a 5-bit coarse row, two nametable select bits (horizontal and vertical) and a 3-bit fine row. The column steps once per 8-pixel tile at a fixed phase inside the tile. The row steps once per line, late in the line. After the visible pixels, the column and the horizontal nametable bit are reloaded from a latch held by the host. The last line of the frame is the pre-render line. On alternate frames it is shortened by one cycle when rendering is on.

Top module: `scanline_seq`

## Requirements
- R1: `cycle_o` counts 0 to 340 and then returns to 0. At that return `line_o` advances, and after line 261 (the pre-render line) `line_o` returns to 0.
- R2: `pixel_valid_o` is high exactly when `line_o` < 240 and `cycle_o` < 256.
- R3: On a visible line with `render_en_i` high, the clock edge that ends cycle 3, 11, 19, … 251 adds one to coarse X in `vaddr_o[4:0]`. No coarse X step happens on other cycles or on non-visible lines.
- R4: A coarse X step from 31 goes to 0 and inverts the horizontal nametable bit `vaddr_o[10]`.
- R5: On a visible line with `render_en_i` high, the edge that ends cycle 251 adds one to fine Y in `vaddr_o[14:12]`. When fine Y goes from 7 to 0, coarse Y in `vaddr_o[9:5]` steps. Coarse Y goes from 29 to 0 and inverts the vertical nametable bit `vaddr_o[11]`.
- R6: On a visible line with `render_en_i` high, the edge that ends cycle 257 copies `hlatch_i[4:0]` into `vaddr_o[4:0]` and `hlatch_i[5]` into `vaddr_o[10]`.
- R7: While `render_en_i` is low, `vaddr_o` does not change. Stepping resumes on the next step cycle after it goes high again.
- R8: The frames after reset alternate even and odd, starting with even. On an odd frame, if `render_en_i` is high at cycle 339 of the pre-render line, that line ends at cycle 339. Otherwise every line ends at cycle 340.
- R9: While `rst_ni` is low, `cycle_o`, `line_o` and `vaddr_o` are 0, and the next frame is even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| render_en_i | input | 1 | Rendering enable; gates address strobes and the short line |
| hlatch_i | input | 6 | Horizontal reload value: [4:0] coarse X, [5] horizontal nametable bit |
| cycle_o | output | 9 | Cycle within the current line |
| line_o | output | 9 | Line within the frame |
| pixel_valid_o | output | 1 | Current cycle produces a visible pixel |
| vaddr_o | output | 15 | Scroll address: [14:12] fine Y, [11] vertical NT, [10] horizontal NT, [9:5] coarse Y, [4:0] coarse X |

## Verification
The counters are registered, and `pixel_valid_o` is decoded from them in the same cycle. So a pixel-valid check samples while the counters show the cycle being tested. An address strobe is decoded from the cycle shown, and its result appears one edge later. The effect of cycle 3 is therefore seen when `cycle_o` reads 4, the effect of 251 at 252, and the effect of 257 at 258. The bench steps to an exact frame, line and cycle, and reads the outputs on the falling edge. To keep the run short it shrinks the frame to 24 visible lines out of 28, and leaves the line timing at its full size.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int CX_W  = 5;
  localparam int CY_W  = 5;
  localparam int FY_W  = 3;
  localparam int VA_W  = FY_W + 2 + CY_W + CX_W;
  localparam int HL_W  = CX_W + 1;
  localparam logic [CY_W-1:0] CY_LAST = CY_W'(29);

  typedef struct packed {
    logic [FY_W-1:0] fine_y;
    logic            nt_v;
    logic            nt_h;
    logic [CY_W-1:0] coarse_y;
    logic [CX_W-1:0] coarse_x;
  } vaddr_t;

  typedef struct packed {
    logic x_inc;
    logic y_inc;
    logic h_load;
  } strobe_t;
endpackage

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int LINE_CYCLES = 341,
  parameter int FRAME_LINES = 262,
  parameter int CW = 9,
  parameter int LW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          render_en_i,
  output logic [CW-1:0] cycle_o,
  output logic [LW-1:0] line_o
);
  localparam logic [CW-1:0] CYC_LAST  = CW'(LINE_CYCLES - 1);
  localparam logic [CW-1:0] CYC_SHORT = CW'(LINE_CYCLES - 2);
  localparam logic [LW-1:0] LINE_LAST = LW'(FRAME_LINES - 1);

  logic odd_q;
  logic short_line;
  logic line_end;

  assign short_line = odd_q & render_en_i & (line_o == LINE_LAST);
  assign line_end   = (cycle_o == CYC_LAST) | (short_line & (cycle_o == CYC_SHORT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cycle_o <= '0;
      line_o  <= '0;
      odd_q   <= 1'b0;
    end else if (line_end) begin
      cycle_o <= '0;
      if (line_o == LINE_LAST) begin
        line_o <= '0;
        odd_q  <= ~odd_q;
      end else begin
        line_o <= line_o + 1'b1;
      end
    end else begin
      cycle_o <= cycle_o + 1'b1;
    end
  end
endmodule

// File: rtl/scan_strobe.sv
module scan_strobe
  import scan_pkg::*;
#(
  parameter int VIS_CYCLES  = 256,
  parameter int VIS_LINES   = 240,
  parameter int TILE_W      = 8,
  parameter int XINC_PHASE  = 3,
  parameter int YINC_CYCLE  = 251,
  parameter int HLOAD_CYCLE = 257,
  parameter int CW = 9,
  parameter int LW = 9
) (
  input  logic          render_en_i,
  input  logic [CW-1:0] cycle_i,
  input  logic [LW-1:0] line_i,
  output strobe_t       strobe_o
);
  localparam int TW = $clog2(TILE_W);
  localparam logic [CW-1:0] VIS_C = CW'(VIS_CYCLES);
  localparam logic [LW-1:0] VIS_L = LW'(VIS_LINES);
  localparam logic [CW-1:0] Y_C   = CW'(YINC_CYCLE);
  localparam logic [CW-1:0] H_C   = CW'(HLOAD_CYCLE);
  localparam logic [TW-1:0] PH    = TW'(XINC_PHASE);

  logic active;

  assign active = render_en_i & (line_i < VIS_L);

  always_comb begin
    strobe_o.x_inc  = active & (cycle_i < VIS_C) & (cycle_i[TW-1:0] == PH);
    strobe_o.y_inc  = active & (cycle_i == Y_C);
    strobe_o.h_load = active & (cycle_i == H_C);
  end
endmodule

// File: rtl/scroll_addr.sv
module scroll_addr
  import scan_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  strobe_t         strobe_i,
  input  logic [HL_W-1:0] hlatch_i,
  output vaddr_t          vaddr_o
);
  function automatic vaddr_t x_step(vaddr_t a);
    vaddr_t r;
    r = a;
    if (a.coarse_x == '1) begin
      r.coarse_x = '0;
      r.nt_h     = ~a.nt_h;
    end else begin
      r.coarse_x = a.coarse_x + 1'b1;
    end
    return r;
  endfunction

  function automatic vaddr_t y_step(vaddr_t a);
    vaddr_t r;
    r = a;
    if (a.fine_y != '1) begin
      r.fine_y = a.fine_y + 1'b1;
    end else begin
      r.fine_y = '0;
      if (a.coarse_y == CY_LAST) begin
        r.coarse_y = '0;
        r.nt_v     = ~a.nt_v;
      end else begin
        r.coarse_y = a.coarse_y + 1'b1;
      end
    end
    return r;
  endfunction

  vaddr_t nxt;

  // x and y strobes coincide on the last tile; both apply
  always_comb begin
    nxt = vaddr_o;
    if (strobe_i.x_inc) nxt = x_step(nxt);
    if (strobe_i.y_inc) nxt = y_step(nxt);
    if (strobe_i.h_load) begin
      nxt.coarse_x = hlatch_i[CX_W-1:0];
      nxt.nt_h     = hlatch_i[CX_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vaddr_o <= '0;
    else         vaddr_o <= nxt;
  end
endmodule

// File: rtl/scanline_seq.sv
module scanline_seq
  import scan_pkg::*;
#(
  parameter int LINE_CYCLES = 341,
  parameter int VIS_CYCLES  = 256,
  parameter int VIS_LINES   = 240,
  parameter int FRAME_LINES = 262,
  parameter int TILE_W      = 8,
  parameter int XINC_PHASE  = 3,
  parameter int YINC_CYCLE  = 251,
  parameter int HLOAD_CYCLE = 257,
  localparam int CW = $clog2(LINE_CYCLES),
  localparam int LW = $clog2(FRAME_LINES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            render_en_i,
  input  logic [HL_W-1:0] hlatch_i,
  output logic [CW-1:0]   cycle_o,
  output logic [LW-1:0]   line_o,
  output logic            pixel_valid_o,
  output logic [VA_W-1:0] vaddr_o
);
  localparam logic [CW-1:0] VIS_C = CW'(VIS_CYCLES);
  localparam logic [LW-1:0] VIS_L = LW'(VIS_LINES);

  strobe_t strobe;
  vaddr_t  vaddr_q;

  scan_counter #(
    .LINE_CYCLES(LINE_CYCLES), .FRAME_LINES(FRAME_LINES), .CW(CW), .LW(LW)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .render_en_i(render_en_i),
    .cycle_o(cycle_o), .line_o(line_o)
  );

  scan_strobe #(
    .VIS_CYCLES(VIS_CYCLES), .VIS_LINES(VIS_LINES), .TILE_W(TILE_W),
    .XINC_PHASE(XINC_PHASE), .YINC_CYCLE(YINC_CYCLE), .HLOAD_CYCLE(HLOAD_CYCLE),
    .CW(CW), .LW(LW)
  ) u_stb (
    .render_en_i(render_en_i), .cycle_i(cycle_o), .line_i(line_o), .strobe_o(strobe)
  );

  scroll_addr u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe),
    .hlatch_i(hlatch_i), .vaddr_o(vaddr_q)
  );

  assign vaddr_o       = vaddr_q;
  assign pixel_valid_o = (cycle_o < VIS_C) & (line_o < VIS_L);
endmodule

// File: rtl/scanline_seq_chk.sv
module scanline_seq_chk #(
  parameter int LINE_CYCLES = 341,
  parameter int VIS_CYCLES  = 256,
  parameter int VIS_LINES   = 240,
  parameter int TILE_W      = 8,
  parameter int XINC_PHASE  = 3,
  parameter int YINC_CYCLE  = 251,
  parameter int HLOAD_CYCLE = 257,
  parameter int CW = 9,
  parameter int LW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          render_en_i,
  input logic [5:0]    hlatch_i,
  input logic [CW-1:0] cycle_o,
  input logic [LW-1:0] line_o,
  input logic [14:0]   vaddr_o
);
  localparam int TW = $clog2(TILE_W);
  localparam logic [CW-1:0] CYC_N = CW'(LINE_CYCLES);
  localparam logic [CW-1:0] VIS_C = CW'(VIS_CYCLES);
  localparam logic [LW-1:0] VIS_L = LW'(VIS_LINES);
  localparam logic [CW-1:0] Y_C   = CW'(YINC_CYCLE);
  localparam logic [CW-1:0] H_C   = CW'(HLOAD_CYCLE);
  localparam logic [TW-1:0] PH    = TW'(XINC_PHASE);

  logic live;
  logic x_slot;
  assign live   = render_en_i & (line_o < VIS_L);
  assign x_slot = live & (((cycle_o < VIS_C) & (cycle_o[TW-1:0] == PH)) | (cycle_o == H_C));

  a_r1_cycle_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_o < CYC_N);

  a_r1_cycle_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_o != '0) |-> (cycle_o == $past(cycle_o) + 1'b1));

  a_r3_x_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !x_slot |=> $stable(vaddr_o[4:0]));

  a_r5_fine_y_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live & (cycle_o == Y_C)) |=> (vaddr_o[14:12] == $past(vaddr_o[14:12]) + 3'd1));

  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live & (cycle_o == H_C)) |=>
      (vaddr_o[4:0] == $past(hlatch_i[4:0])) && (vaddr_o[10] == $past(hlatch_i[5])));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !render_en_i |=> $stable(vaddr_o));
endmodule

bind scanline_seq scanline_seq_chk #(
  .LINE_CYCLES(LINE_CYCLES), .VIS_CYCLES(VIS_CYCLES), .VIS_LINES(VIS_LINES),
  .TILE_W(TILE_W), .XINC_PHASE(XINC_PHASE), .YINC_CYCLE(YINC_CYCLE),
  .HLOAD_CYCLE(HLOAD_CYCLE), .CW(CW), .LW(LW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .render_en_i(render_en_i), .hlatch_i(hlatch_i),
  .cycle_o(cycle_o), .line_o(line_o), .vaddr_o(vaddr_o)
);

// File: tb/scanline_seq_test.sv
`timescale 1ns/1ps
module scanline_seq_test;
  localparam int TB_LINES = 28;
  localparam int TB_VIS   = 24;
  localparam int LW       = $clog2(TB_LINES);

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        render_en_i;
  logic [5:0]  hlatch_i;
  logic [8:0]  cycle_o;
  logic [LW-1:0] line_o;
  logic        pixel_valid_o;
  logic [14:0] vaddr_o;

  int checks = 0;
  int errors = 0;
  int frames = 0;
  int ticks  = 0;

  always #2.5 clk_i = ~clk_i;

  scanline_seq #(.VIS_LINES(TB_VIS), .FRAME_LINES(TB_LINES)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .render_en_i(render_en_i), .hlatch_i(hlatch_i),
    .cycle_o(cycle_o), .line_o(line_o), .pixel_valid_o(pixel_valid_o), .vaddr_o(vaddr_o)
  );

  always @(posedge clk_i) begin
    ticks++;
    if (ticks > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", ticks);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    if (cycle_o == 9'd0 && line_o == '0) frames++;
  endtask

  task automatic go(input int f, input int l, input int c);
    while (!(frames == f && int'(line_o) == l && int'(cycle_o) == c)) step();
  endtask

  typedef struct packed {
    int l; int c; int va; int pv; int req;
  } vec_t;

  // frame 0, hlatch = 5
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{0,   3, 32'h0000, 1, 3},  // R3 no step before cycle 3 ends
    '{0,   4, 32'h0001, 1, 3},  // R3
    '{0,  12, 32'h0002, 1, 3},  // R3
    '{0, 251, 32'h001F, 1, 5},  // R5 not yet
    '{0, 252, 32'h1400, 1, 4},  // R4 wrap toggles bit 10, R5 fine y
    '{0, 255, 32'h1400, 1, 2},  // R2
    '{0, 256, 32'h1400, 0, 2},  // R2
    '{0, 258, 32'h1005, 0, 6},  // R6
    '{1,   4, 32'h1006, 1, 3},  // R3
    '{1, 258, 32'h2005, 0, 5},  // R5
    '{7, 258, 32'h0025, 0, 5},  // R5 coarse y step
    '{24,  0, 32'h0065, 0, 2},  // R2 non-visible line
    '{24,100, 32'h0065, 0, 3}   // R3 no step off visible lines
  };

  initial begin
    rst_ni = 1'b0;
    render_en_i = 1'b1;
    hlatch_i = 6'd5;
    repeat (3) @(negedge clk_i);
    check("R9 cycle", int'(cycle_o), 0);
    check("R9 line", int'(line_o), 0);
    check("R9 vaddr", int'(vaddr_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      go(0, VECS[i].l, VECS[i].c);
      check($sformatf("R%0d vec %0d vaddr", VECS[i].req, i), int'(vaddr_o), VECS[i].va);
      check($sformatf("R%0d vec %0d pixel", VECS[i].req, i), int'(pixel_valid_o), VECS[i].pv);
    end

    go(0, TB_LINES-1, 339);
    step();
    check("R8 even frame full line", int'(cycle_o), 340);
    step();
    check("R1 wrap cycle", int'(cycle_o), 0);
    check("R1 wrap line", int'(line_o), 0);
    check("R1 frame count", frames, 1);

    go(1, 0, 4);
    check("R3 next frame", int'(vaddr_o), 32'h0066);

    go(1, TB_LINES-1, 339);
    step();
    check("R8 odd frame short cycle", int'(cycle_o), 0);
    check("R8 odd frame short line", int'(line_o), 0);

    go(9, TB_VIS-1, 251);
    check("R5 before coarse y wrap", int'(vaddr_o), 32'h77A4);
    step();
    check("R5 coarse y wrap toggles bit 11", int'(vaddr_o), 32'h0C05);
    go(9, TB_VIS-1, 258);
    check("R6 reload after wrap", int'(vaddr_o), 32'h0805);

    render_en_i = 1'b0;
    go(9, TB_LINES-1, 339);
    step();
    check("R8 odd frame disabled full line", int'(cycle_o), 340);
    go(10, 0, 4);
    check("R7 hold at x slot", int'(vaddr_o), 32'h0805);
    go(10, 0, 258);
    check("R7 hold past reload", int'(vaddr_o), 32'h0805);
    render_en_i = 1'b1;
    go(10, 1, 4);
    check("R7 resume step", int'(vaddr_o), 32'h0806);

    rst_ni = 1'b0;
    #1;
    check("R9 async cycle", int'(cycle_o), 0);
    check("R9 async line", int'(line_o), 0);
    check("R9 async vaddr", int'(vaddr_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule